// File: doc/BRIEF.md
# Programmable frame-sync pulse generator

This block produces a periodic, active-high frame-synchronization pulse for a serial port. It runs on the system clock. It moves forward only on cycles where a one-cycle bit-clock enable tick is high, so every length below is counted in bit-clock ticks. Two configuration fields set the frame. The frame length is one plus a 12-bit period value, and the pulse length is one plus an 8-bit width value. Each value is loaded into its own down-counter at the start of every frame.

A sync-mode input switches the block away from free-running frames. In sync mode the period value has no effect. A new pulse starts only when the external sync input shows a rising edge, judged from its values on two successive ticks. The pulse then lasts for the programmed width.

Top module: `fsync_gen`

## Requirements
- R1: In free-running mode (sync_mode = 0) a frame starts on the first tick after reset. After that, frames start every period_cfg + 1 ticks, so period_cfg in 0..4095 gives 1..4096 ticks. After the k-th tick since the last frame start (k = 0 at the start), fsync_out is 1 when k <= width_cfg and 0 otherwise.
- R2: Each pulse stays high for width_cfg + 1 ticks, so width_cfg in 0..255 gives 1..256 ticks. For example, period_cfg = 15 with width_cfg = 1 gives 2 high ticks out of every 16.
- R3: fsync_out is a register. It changes only on the clock edge of a cycle where bit_tick = 1. With bit_tick = 0 it holds its value.
- R4: When width_cfg >= period_cfg, fsync_out stays high without a gap across frame boundaries. This includes period_cfg = 0.
- R5: A synchronous, active-high rst drives fsync_out to 0 and clears both counters. It also clears the stored sync sample.
- R6: In sync mode, period_cfg has no effect. No pulse starts unless ext_sync has a rising edge.
- R7: In sync mode, a tick where ext_sync = 1 and ext_sync was 0 on the previous tick (or since reset) starts a pulse of width_cfg + 1 ticks. Holding ext_sync high does not start another pulse.
- R8: width_cfg and period_cfg are loaded only at the start of a frame. A change during a frame takes effect from the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle bit-clock enable |
| period_cfg | input | 12 | Frame length minus one, in ticks |
| width_cfg | input | 8 | Pulse length minus one, in ticks |
| sync_mode | input | 1 | 1 = frames start only from ext_sync edges |
| ext_sync | input | 1 | External sync input, sampled on ticks |
| fsync_out | output | 1 | Registered frame-sync pulse |

## Verification
The hardest case to reach is a width change in the middle of a frame. The new value must be ignored by the pulse already running, yet govern the next one. To get there, the stimulus starts a short frame, waits until the pulse has ended, and rewrites width_cfg. It then follows the output tick by tick through the rest of the frame and the whole of the next. In sync mode, the stimulus holds ext_sync high across many ticks to show that a level alone does not start a pulse. It also changes period_cfg between sync pulses to show that the period value has no effect.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int unsigned PERIOD_BITS = 12;
  localparam int unsigned WIDTH_BITS  = 8;
endpackage

// File: rtl/fsync_down_cnt.sv
module fsync_down_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             is_zero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (en) begin
      if (load)
        count <= load_val;
      else if (count != '0)
        count <= count - 1'b1;
    end
  end

  assign is_zero = (count == '0);
endmodule

// File: rtl/fsync_edge_det.sv
module fsync_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic prev,
  output logic rise
);
  always_ff @(posedge clk) begin
    if (rst)
      prev <= 1'b0;
    else if (en)
      prev <= din;
  end

  assign rise = din & ~prev;
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
  import fsync_pkg::*;
#(
  parameter int unsigned PER_W = PERIOD_BITS,
  parameter int unsigned WID_W = WIDTH_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic [PER_W-1:0] period_cfg,
  input  logic [WID_W-1:0] width_cfg,
  input  logic             sync_mode,
  input  logic             ext_sync,
  output logic             fsync_out
);
  logic [PER_W-1:0] per_count;
  logic             per_zero;
  logic [WID_W-1:0] wid_count;
  logic             wid_zero;
  logic             sync_prev;
  logic             sync_rise;
  logic             per_load;
  logic [PER_W-1:0] per_load_val;
  logic             frame_start;
  logic             pulse_q;

  // The period counter is parked at zero in sync mode.
  assign per_load     = per_zero | sync_mode;
  assign per_load_val = sync_mode ? '0 : period_cfg;
  assign frame_start  = sync_mode ? sync_rise : per_zero;

  fsync_down_cnt #(.CNT_W(PER_W)) per_cnt_i (
    .clk      (clk),
    .rst      (rst),
    .en       (bit_tick),
    .load     (per_load),
    .load_val (per_load_val),
    .count    (per_count),
    .is_zero  (per_zero)
  );

  fsync_down_cnt #(.CNT_W(WID_W)) wid_cnt_i (
    .clk      (clk),
    .rst      (rst),
    .en       (bit_tick),
    .load     (frame_start),
    .load_val (width_cfg),
    .count    (wid_count),
    .is_zero  (wid_zero)
  );

  fsync_edge_det sync_det_i (
    .clk  (clk),
    .rst  (rst),
    .en   (bit_tick),
    .din  (ext_sync),
    .prev (sync_prev),
    .rise (sync_rise)
  );

  always_ff @(posedge clk) begin
    if (rst)
      pulse_q <= 1'b0;
    else if (bit_tick) begin
      if (frame_start)
        pulse_q <= 1'b1;
      else if (wid_zero)
        pulse_q <= 1'b0;
    end
  end

  assign fsync_out = pulse_q;
endmodule

// File: rtl/fsync_gen_chk.sv
module fsync_gen_chk (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic sync_mode,
  input logic ext_sync,
  input logic per_zero,
  input logic sync_prev,
  input logic fsync_out
);
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(fsync_out));

  p_reset_low_r5: assert property (@(posedge clk)
    rst |=> !fsync_out);

  p_frame_start_r1: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && !sync_mode && per_zero) |=> fsync_out);

  p_sync_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && sync_mode && ext_sync && !sync_prev) |=> fsync_out);

  p_sync_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && sync_mode && !fsync_out && !(ext_sync && !sync_prev)) |=> !fsync_out);
endmodule

bind fsync_gen fsync_gen_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .bit_tick  (bit_tick),
  .sync_mode (sync_mode),
  .ext_sync  (ext_sync),
  .per_zero  (per_zero),
  .sync_prev (sync_prev),
  .fsync_out (fsync_out)
);

// File: tb/fsync_gen_tb_top.sv
module fsync_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_tick = 1'b0;
  logic [11:0] period_cfg = '0;
  logic [7:0]  width_cfg = '0;
  logic        sync_mode = 1'b0;
  logic        ext_sync = 1'b0;
  logic        fsync_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fsync_gen dut_i (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .period_cfg (period_cfg),
    .width_cfg  (width_cfg),
    .sync_mode  (sync_mode),
    .ext_sync   (ext_sync),
    .fsync_out  (fsync_out)
  );

  // {period, width} pairs for free-running frames (R1, R2, R4)
  localparam logic [19:0] VECS [0:6] = '{
    {12'd15,   8'd1},
    {12'd3,    8'd5},
    {12'd0,    8'd0},
    {12'd7,    8'd0},
    {12'd4,    8'd4},
    {12'd9,    8'd3},
    {12'd4095, 8'd255}
  };

  task automatic check(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: fsync_out=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    bit_tick = 1'b0;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  // One tick cycle followed by one quiet cycle; sample afterwards.
  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  initial begin
    // R5: output low out of reset
    @(negedge clk);
    @(negedge clk);
    check("R5 reset low", fsync_out, 1'b0);
    rst = 1'b0;

    // Table walk: R1/R2/R4 over two frames each
    for (int v = 0; v < 7; v++) begin
      int errs;
      int p;
      int w;
      p = int'(VECS[v][19:8]);
      w = int'(VECS[v][7:0]);
      period_cfg = VECS[v][19:8];
      width_cfg  = VECS[v][7:0];
      do_reset();
      errs = 0;
      for (int k = 0; k < 2 * (p + 1); k++) begin
        logic exp;
        tick();
        exp = ((k % (p + 1)) <= w);
        if (fsync_out !== exp) begin
          errs++;
          if (errs == 1)
            $display("FAIL R1/R2/R4 vec %0d tick %0d: fsync_out=%0b expected %0b",
                     v, k, fsync_out, exp);
        end
      end
      n_checks++;
      if (errs != 0) n_fail++;
    end

    // R3: no change between ticks
    period_cfg = 12'd15; width_cfg = 8'd1;
    do_reset();
    tick();
    check("R3 start high", fsync_out, 1'b1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R3 hold high", fsync_out, 1'b1);
    end
    tick();
    check("R2 second tick high", fsync_out, 1'b1);
    tick();
    check("R2 third tick low", fsync_out, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R3 hold low", fsync_out, 1'b0);
    end

    // R5: reset in mid-pulse, then immediate frame start
    tick();
    do_reset();
    tick();
    check("R5 frame on first tick", fsync_out, 1'b1);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R5 reset clears pulse", fsync_out, 1'b0);

    // R8: width change during a frame
    period_cfg = 12'd7; width_cfg = 8'd1;
    do_reset();
    for (int k = 0; k < 16; k++) begin
      logic exp;
      if (k == 3) width_cfg = 8'd5;
      tick();
      if (k < 8) exp = (k <= 1);
      else       exp = ((k % 8) <= 5);
      check("R8 reload at frame start", fsync_out, exp);
    end

    // R6/R7: sync mode
    sync_mode = 1'b1; period_cfg = 12'd5; width_cfg = 8'd2; ext_sync = 1'b0;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      tick();
      check("R6 no free-run", fsync_out, 1'b0);
    end
    ext_sync = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick();
      check("R7 rise pulse then level ignored", fsync_out, (i <= 2));
    end
    ext_sync = 1'b0;
    tick();
    check("R7 low after drop", fsync_out, 1'b0);
    period_cfg = 12'd4095;
    ext_sync = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R6 period ignored", fsync_out, (i <= 2));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule